// File: doc/BRIEF.md
# Integer Execute Unit with Status Flags

This block is the integer execute stage of a small RISC core. Each accepted operation brings two register operand values, a raw 16-bit immediate field, an operation code and two candidate write-back register indices. One clock later the block presents a 32-bit result, the index of the register to write and a write enable. On that same edge it updates a four-bit status word holding zero, sign, carry and overflow. Decode, the register file and multiply/divide live elsewhere.

Operations enter on a valid/ready handshake and leave through a one-entry output register with its own valid/ready pair. The input side is ready whenever the output register is empty or is being drained in the same cycle. While the consumer holds `out_ready` low, the presented result stays frozen, no new operation is taken and the status word holds its value. The status word is a plain output that changes only when an operation is accepted.

Which flags an operation writes depends on its class. Arithmetic and shift operations rewrite all four flags. Logical operations clear overflow and leave carry as it was. Moves and the address-forming additions leave every flag alone.

Top module: `ex_alu`

## Requirements
- R1: Operation codes on `in_op`: 0 add, 1 add short immediate, 2 add long immediate, 3 subtract, 4 reverse subtract, 5 move, 6 move short immediate, 7 add-address long immediate, 8 add-high immediate, 9 and, 10 and immediate, 11 or, 12 or immediate, 13 xor, 14 xor immediate, 15 not, 16 shift-left by register, 17 shift-left by immediate, 18 logical shift-right by register, 19 logical shift-right by immediate, 20 arithmetic shift-right by register, 21 arithmetic shift-right by immediate. Add gives B+A. Add short immediate gives B plus `in_imm[4:0]` sign-extended. Add long immediate gives A plus `in_imm[15:0]` sign-extended.
- R2: `flags` bit 0 is zero, bit 1 is sign, bit 2 is carry and bit 3 is overflow. For codes 0 to 2, zero is set when the result is all zeros and sign equals result bit 31. Carry is set on unsigned wrap. Overflow is set when both addends share a sign bit and the result's sign bit differs from it.
- R3: Subtract gives B-A. Reverse subtract gives A-B. Both write zero and sign from the result. Carry is set on unsigned borrow. Overflow is set when the operand signs differ and the result sign differs from the minuend's sign.
- R4: Move gives A. Move short immediate gives `in_imm[4:0]` sign-extended. Add-address gives A plus `in_imm` sign-extended. Add-high gives A plus `{in_imm,16'h0}`. None of these four changes any flag.
- R5: The logical codes 9 to 15 give A&B, A|B and A^B, the same three with `in_imm` zero-extended in place of B, and ~A. They write zero and sign from the result, clear overflow and keep carry.
- R6: Shifts operate on B. The amount is `in_a[4:0]` for the register forms and `in_imm[4:0]` for the immediate forms, and higher bits are ignored. Arithmetic right shift replicates bit 31. The other two shifts fill with zeros.
- R7: Shifts write zero and sign from the result and clear overflow. Carry takes the last bit shifted out, and is 0 when the amount is 0.
- R8: Codes 2, 7, 8, 10, 12 and 14 write back to `in_idx_d`. All other defined codes write back to `in_idx_b`. Every defined code presents `out_wb_en`=1.
- R9: Codes 22 to 31 are still accepted. They present `out_wb_en`=0 and result 0, and leave the flags unchanged.
- R10: `in_ready` is 1 whenever the output register is empty or `out_ready` is 1. While `out_valid`=1 and `out_ready`=0, the output holds unchanged. The flags change only on the edge where an operation is accepted.
- R11: After reset `out_valid`=0, `flags`=0 and `in_ready`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Operation can be taken this cycle |
| in_op | input | 5 | Operation code |
| in_a | input | 32 | First register operand value |
| in_b | input | 32 | Second register operand value |
| in_imm | input | 16 | Raw immediate field |
| in_idx_b | input | 5 | Index of the second register (two-operand destination) |
| in_idx_d | input | 5 | Separate destination index for three-operand immediate forms |
| out_valid | output | 1 | Result register holds an operation |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_result | output | 32 | Result value |
| out_wb_idx | output | 5 | Register to write |
| out_wb_en | output | 1 | Write-back enable |
| flags | output | 4 | Status word {overflow, carry, sign, zero} |

## Verification
The hardest situation to reach is a logical operation that must keep a carry left set by an earlier operation while the consumer stalls the output. At the ports it looks exactly like one that clears the carry, unless the carry was 1 beforehand and the operation arrives during back-pressure. The stimulus runs directed chains that first set the carry through an add wrap or a shift, then issue logical ops and flag-free moves with `out_ready` held low for several cycles. A long random phase follows that biases operands toward 0, all-ones and the two sign-boundary values, and register shift amounts toward values above 31.

// File: rtl/ex_alu_pkg.sv
package ex_alu_pkg;

  typedef enum logic [4:0] {
    OP_ADD    = 5'd0,
    OP_ADDS   = 5'd1,
    OP_ADDL   = 5'd2,
    OP_SUB    = 5'd3,
    OP_RSUB   = 5'd4,
    OP_MOV    = 5'd5,
    OP_MOVS   = 5'd6,
    OP_ADDRL  = 5'd7,
    OP_ADDHI  = 5'd8,
    OP_AND    = 5'd9,
    OP_ANDL   = 5'd10,
    OP_OR     = 5'd11,
    OP_ORL    = 5'd12,
    OP_XOR    = 5'd13,
    OP_XORL   = 5'd14,
    OP_NOT    = 5'd15,
    OP_SLL    = 5'd16,
    OP_SLLI   = 5'd17,
    OP_SRL    = 5'd18,
    OP_SRLI   = 5'd19,
    OP_SRA    = 5'd20,
    OP_SRAI   = 5'd21
  } alu_op_e;

  typedef enum logic [2:0] {U_NONE, U_ADD, U_SUB, U_LOGIC, U_SHIFT} unit_e;
  typedef enum logic [1:0] {L_AND, L_OR, L_XOR, L_NOT} logic_fn_e;
  typedef enum logic [1:0] {S_LL, S_RL, S_RA} shift_fn_e;
  typedef enum logic [1:0] {F_KEEP, F_ALL, F_LOGIC} flag_upd_e;

  typedef struct packed {
    unit_e     unit;
    logic_fn_e lfn;
    shift_fn_e sfn;
    flag_upd_e fup;
    logic      wen;
  } ctrl_t;

  typedef struct packed {
    logic ov;
    logic cy;
    logic s;
    logic z;
  } status_t;

endpackage

// File: rtl/ex_alu_decode.sv
module ex_alu_decode
  import ex_alu_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int IDX_W   = 5,
  parameter int IMM_W   = 16,
  parameter int SHORT_W = 5
) (
  input  logic [4:0]              op,
  input  logic [DATA_W-1:0]       a,
  input  logic [DATA_W-1:0]       b,
  input  logic [IMM_W-1:0]        imm,
  input  logic [IDX_W-1:0]        idx_b,
  input  logic [IDX_W-1:0]        idx_d,
  output ctrl_t                   ctl,
  output logic [DATA_W-1:0]       x,
  output logic [DATA_W-1:0]       y,
  output logic [$clog2(DATA_W)-1:0] amt,
  output logic [IDX_W-1:0]        wb_idx
);
  localparam int SH_W = $clog2(DATA_W);

  logic [DATA_W-1:0] imm_s5, imm_s16, imm_z16, imm_hi;

  assign imm_s5  = {{(DATA_W-SHORT_W){imm[SHORT_W-1]}}, imm[SHORT_W-1:0]};
  assign imm_s16 = {{(DATA_W-IMM_W){imm[IMM_W-1]}}, imm};
  assign imm_z16 = {{(DATA_W-IMM_W){1'b0}}, imm};
  assign imm_hi  = {imm, {(DATA_W-IMM_W){1'b0}}};

  always_comb begin
    ctl    = '0;
    x      = b;
    y      = a;
    amt    = imm[SH_W-1:0];
    wb_idx = idx_b;
    case (op)
      OP_ADD:   begin ctl.unit = U_ADD; ctl.fup = F_ALL; ctl.wen = 1'b1; end
      OP_ADDS:  begin ctl.unit = U_ADD; ctl.fup = F_ALL; ctl.wen = 1'b1; y = imm_s5; end
      OP_ADDL:  begin ctl.unit = U_ADD; ctl.fup = F_ALL; ctl.wen = 1'b1;
                      x = a; y = imm_s16; wb_idx = idx_d; end
      OP_SUB:   begin ctl.unit = U_SUB; ctl.fup = F_ALL; ctl.wen = 1'b1; end
      OP_RSUB:  begin ctl.unit = U_SUB; ctl.fup = F_ALL; ctl.wen = 1'b1; x = a; y = b; end
      OP_MOV:   begin ctl.unit = U_ADD; ctl.wen = 1'b1; x = a; y = '0; end
      OP_MOVS:  begin ctl.unit = U_ADD; ctl.wen = 1'b1; x = imm_s5; y = '0; end
      OP_ADDRL: begin ctl.unit = U_ADD; ctl.wen = 1'b1; x = a; y = imm_s16; wb_idx = idx_d; end
      OP_ADDHI: begin ctl.unit = U_ADD; ctl.wen = 1'b1; x = a; y = imm_hi; wb_idx = idx_d; end
      OP_AND:   begin ctl.unit = U_LOGIC; ctl.lfn = L_AND; ctl.fup = F_LOGIC; ctl.wen = 1'b1;
                      x = a; y = b; end
      OP_ANDL:  begin ctl.unit = U_LOGIC; ctl.lfn = L_AND; ctl.fup = F_LOGIC; ctl.wen = 1'b1;
                      x = a; y = imm_z16; wb_idx = idx_d; end
      OP_OR:    begin ctl.unit = U_LOGIC; ctl.lfn = L_OR; ctl.fup = F_LOGIC; ctl.wen = 1'b1;
                      x = a; y = b; end
      OP_ORL:   begin ctl.unit = U_LOGIC; ctl.lfn = L_OR; ctl.fup = F_LOGIC; ctl.wen = 1'b1;
                      x = a; y = imm_z16; wb_idx = idx_d; end
      OP_XOR:   begin ctl.unit = U_LOGIC; ctl.lfn = L_XOR; ctl.fup = F_LOGIC; ctl.wen = 1'b1;
                      x = a; y = b; end
      OP_XORL:  begin ctl.unit = U_LOGIC; ctl.lfn = L_XOR; ctl.fup = F_LOGIC; ctl.wen = 1'b1;
                      x = a; y = imm_z16; wb_idx = idx_d; end
      OP_NOT:   begin ctl.unit = U_LOGIC; ctl.lfn = L_NOT; ctl.fup = F_LOGIC; ctl.wen = 1'b1;
                      x = a; end
      OP_SLL:   begin ctl.unit = U_SHIFT; ctl.sfn = S_LL; ctl.fup = F_ALL; ctl.wen = 1'b1;
                      amt = a[SH_W-1:0]; end
      OP_SLLI:  begin ctl.unit = U_SHIFT; ctl.sfn = S_LL; ctl.fup = F_ALL; ctl.wen = 1'b1; end
      OP_SRL:   begin ctl.unit = U_SHIFT; ctl.sfn = S_RL; ctl.fup = F_ALL; ctl.wen = 1'b1;
                      amt = a[SH_W-1:0]; end
      OP_SRLI:  begin ctl.unit = U_SHIFT; ctl.sfn = S_RL; ctl.fup = F_ALL; ctl.wen = 1'b1; end
      OP_SRA:   begin ctl.unit = U_SHIFT; ctl.sfn = S_RA; ctl.fup = F_ALL; ctl.wen = 1'b1;
                      amt = a[SH_W-1:0]; end
      OP_SRAI:  begin ctl.unit = U_SHIFT; ctl.sfn = S_RA; ctl.fup = F_ALL; ctl.wen = 1'b1; end
      default:  ctl = '0;
    endcase
  end
endmodule

// File: rtl/ex_alu_arith.sv
module ex_alu_arith #(
  parameter int DATA_W = 32
) (
  input  logic              sub,
  input  logic [DATA_W-1:0] x,
  input  logic [DATA_W-1:0] y,
  output logic [DATA_W-1:0] r,
  output logic              cy,
  output logic              ov
);
  localparam int MSB = DATA_W - 1;

  logic [DATA_W-1:0] y_eff;
  logic [DATA_W:0]   sum;
  logic              same_sign;

  assign y_eff     = sub ? ~y : y;
  assign sum       = {1'b0, x} + {1'b0, y_eff} + {{DATA_W{1'b0}}, sub};
  assign r         = sum[DATA_W-1:0];
  assign cy        = sum[DATA_W] ^ sub;
  assign same_sign = (x[MSB] == y[MSB]);
  assign ov        = (sub ? !same_sign : same_sign) && (r[MSB] != x[MSB]);
endmodule

// File: rtl/ex_alu_logic.sv
module ex_alu_logic
  import ex_alu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic_fn_e         fn,
  input  logic [DATA_W-1:0] x,
  input  logic [DATA_W-1:0] y,
  output logic [DATA_W-1:0] r
);
  always_comb begin
    case (fn)
      L_AND:   r = x & y;
      L_OR:    r = x | y;
      L_XOR:   r = x ^ y;
      default: r = ~x;
    endcase
  end
endmodule

// File: rtl/ex_alu_shift.sv
module ex_alu_shift
  import ex_alu_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int SH_W  = $clog2(DATA_W)
) (
  input  shift_fn_e         fn,
  input  logic [DATA_W-1:0] x,
  input  logic [SH_W-1:0]   amt,
  output logic [DATA_W-1:0] r,
  output logic              cy
);
  logic [DATA_W:0]        left_w, right_w;
  logic signed [DATA_W:0] arith_in, arith_w;

  assign left_w   = {1'b0, x} << amt;
  assign right_w  = {x, 1'b0} >> amt;
  assign arith_in = $signed({x, 1'b0});
  assign arith_w  = arith_in >>> amt;

  always_comb begin
    case (fn)
      S_LL:    begin r = left_w[DATA_W-1:0];  cy = left_w[DATA_W]; end
      S_RL:    begin r = right_w[DATA_W:1];   cy = right_w[0];     end
      default: begin r = arith_w[DATA_W:1];   cy = arith_w[0];     end
    endcase
  end
endmodule

// File: rtl/ex_alu.sv
module ex_alu
  import ex_alu_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int IDX_W   = 5,
  parameter int IMM_W   = 16,
  parameter int SHORT_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [4:0]        in_op,
  input  logic [DATA_W-1:0] in_a,
  input  logic [DATA_W-1:0] in_b,
  input  logic [IMM_W-1:0]  in_imm,
  input  logic [IDX_W-1:0]  in_idx_b,
  input  logic [IDX_W-1:0]  in_idx_d,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_result,
  output logic [IDX_W-1:0]  out_wb_idx,
  output logic              out_wb_en,
  output logic [3:0]        flags
);
  localparam int SH_W = $clog2(DATA_W);

  ctrl_t             ctl;
  logic [DATA_W-1:0] op_x, op_y, ar_r, lg_r, sh_r, res;
  logic [SH_W-1:0]   amt;
  logic [IDX_W-1:0]  wb_idx;
  logic              ar_cy, ar_ov, sh_cy, accept;
  status_t           st_q, st_nxt;

  logic              vld_q, wen_q;
  logic [DATA_W-1:0] res_q;
  logic [IDX_W-1:0]  idx_q;

  ex_alu_decode #(.DATA_W(DATA_W), .IDX_W(IDX_W), .IMM_W(IMM_W), .SHORT_W(SHORT_W)) u_dec (
    .op(in_op), .a(in_a), .b(in_b), .imm(in_imm), .idx_b(in_idx_b), .idx_d(in_idx_d),
    .ctl(ctl), .x(op_x), .y(op_y), .amt(amt), .wb_idx(wb_idx)
  );

  ex_alu_arith #(.DATA_W(DATA_W)) u_arith (
    .sub(ctl.unit == U_SUB), .x(op_x), .y(op_y), .r(ar_r), .cy(ar_cy), .ov(ar_ov)
  );

  ex_alu_logic #(.DATA_W(DATA_W)) u_logic (
    .fn(ctl.lfn), .x(op_x), .y(op_y), .r(lg_r)
  );

  ex_alu_shift #(.DATA_W(DATA_W)) u_shift (
    .fn(ctl.sfn), .x(op_x), .amt(amt), .r(sh_r), .cy(sh_cy)
  );

  always_comb begin
    case (ctl.unit)
      U_ADD, U_SUB: res = ar_r;
      U_LOGIC:      res = lg_r;
      U_SHIFT:      res = sh_r;
      default:      res = '0;
    endcase
  end

  always_comb begin
    st_nxt = st_q;
    case (ctl.fup)
      F_ALL: begin
        st_nxt.z  = (res == '0);
        st_nxt.s  = res[DATA_W-1];
        st_nxt.cy = (ctl.unit == U_SHIFT) ? sh_cy : ar_cy;
        st_nxt.ov = (ctl.unit == U_SHIFT) ? 1'b0 : ar_ov;
      end
      F_LOGIC: begin
        st_nxt.z  = (res == '0);
        st_nxt.s  = res[DATA_W-1];
        st_nxt.ov = 1'b0;
      end
      default: st_nxt = st_q;
    endcase
  end

  assign in_ready = !vld_q || out_ready;
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      wen_q <= 1'b0;
      res_q <= '0;
      idx_q <= '0;
      st_q  <= '0;
    end else if (accept) begin
      vld_q <= 1'b1;
      wen_q <= ctl.wen;
      res_q <= res;
      idx_q <= wb_idx;
      st_q  <= st_nxt;
    end else if (out_ready) begin
      vld_q <= 1'b0;
    end
  end

  assign out_valid  = vld_q;
  assign out_result = res_q;
  assign out_wb_idx = idx_q;
  assign out_wb_en  = wen_q;
  assign flags      = st_q;
endmodule

// File: rtl/ex_alu_chk.sv
module ex_alu_chk
  import ex_alu_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IDX_W  = 5,
  parameter int IMM_W  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic [4:0]        in_op,
  input logic [IMM_W-1:0]  in_imm,
  input logic              out_valid,
  input logic              out_ready,
  input logic [DATA_W-1:0] out_result,
  input logic [IDX_W-1:0]  out_wb_idx,
  input logic              out_wb_en,
  input logic [3:0]        flags
);
  logic take, is_logic, is_move, is_add, is_shi, is_bad;

  assign take     = in_valid && in_ready;
  assign is_add   = (in_op <= OP_ADDL);
  assign is_move  = (in_op >= OP_MOV) && (in_op <= OP_ADDHI);
  assign is_logic = (in_op >= OP_AND) && (in_op <= OP_NOT);
  assign is_shi   = (in_op == OP_SLLI) || (in_op == OP_SRLI) || (in_op == OP_SRAI);
  assign is_bad   = (in_op > OP_SRAI);

  // R10
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_result) && $stable(out_wb_idx) && $stable(out_wb_en));

  // R10
  flag_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !take |=> $stable(flags));

  // R2
  add_zs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take && is_add |=> flags[0] == (out_result == '0) && flags[1] == out_result[DATA_W-1]);

  // R4
  move_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take && is_move |=> $stable(flags) && out_wb_en);

  // R5
  logic_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take && is_logic |=> !flags[3] && flags[2] == $past(flags[2]));

  // R7
  shift_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take && is_shi && in_imm[4:0] == 5'd0 |=> !flags[2] && !flags[3]);

  // R9
  bad_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take && is_bad |=> !out_wb_en && out_result == '0 && $stable(flags));
endmodule

bind ex_alu ex_alu_chk #(.DATA_W(DATA_W), .IDX_W(IDX_W), .IMM_W(IMM_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .in_op(in_op),
  .in_imm(in_imm), .out_valid(out_valid), .out_ready(out_ready), .out_result(out_result),
  .out_wb_idx(out_wb_idx), .out_wb_en(out_wb_en), .flags(flags)
);

// File: tb/ex_alu_tb.sv
`timescale 1ns/1ps
module ex_alu_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0, out_ready = 1'b0;
  logic [4:0]  in_op = '0, in_idx_b = '0, in_idx_d = '0;
  logic [31:0] in_a = '0, in_b = '0;
  logic [15:0] in_imm = '0;
  logic        in_ready, out_valid, out_wb_en;
  logic [31:0] out_result;
  logic [4:0]  out_wb_idx;
  logic [3:0]  flags;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  // reference state after the most recent edge
  bit          m_valid = 1'b0, m_en = 1'b0;
  logic [31:0] m_res = '0;
  logic [4:0]  m_idx = '0;
  logic [3:0]  m_flags = '0;
  string       m_rreq = "R11", m_freq = "R11";

  always #2 clk = ~clk;

  ex_alu u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .in_op(in_op),
    .in_a(in_a), .in_b(in_b), .in_imm(in_imm), .in_idx_b(in_idx_b), .in_idx_d(in_idx_d),
    .out_valid(out_valid), .out_ready(out_ready), .out_result(out_result),
    .out_wb_idx(out_wb_idx), .out_wb_en(out_wb_en), .flags(flags)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic void model(input int op, input logic [31:0] a, b, input logic [15:0] imm,
                                input logic [4:0] ib, id, input logic [3:0] fin,
                                output logic [31:0] r, output bit en, output logic [4:0] idx,
                                output logic [3:0] fo);
    logic [31:0] s5, s16, z16, x, y;
    longint      wide;
    int          amt;
    bit          c, v;
    s5  = {{27{imm[4]}}, imm[4:0]};
    s16 = {{16{imm[15]}}, imm};
    z16 = {16'h0, imm};
    fo  = fin;
    en  = (op <= 21);
    idx = (op == 2 || op == 7 || op == 8 || op == 10 || op == 12 || op == 14) ? id : ib;
    r   = 32'h0;
    amt = (op == 16 || op == 18 || op == 20) ? int'(a[4:0]) : int'(imm[4:0]);
    if (op <= 2) begin
      x = (op == 2) ? a : b;
      y = (op == 0) ? a : (op == 1) ? s5 : s16;
      wide = longint'(x) + longint'(y);
      r = wide[31:0];
      c = (wide > 64'h0000_0000_FFFF_FFFF);
      v = (x[31] == y[31]) && (r[31] != x[31]);
      fo = {v, c, r[31], r == 0};
    end else if (op <= 4) begin
      x = (op == 3) ? b : a;
      y = (op == 3) ? a : b;
      r = x - y;
      c = (x < y);
      v = (x[31] != y[31]) && (r[31] != x[31]);
      fo = {v, c, r[31], r == 0};
    end else if (op <= 8) begin
      case (op)
        5: r = a;
        6: r = s5;
        7: r = a + s16;
        default: r = a + {imm, 16'h0};
      endcase
    end else if (op <= 15) begin
      case (op)
        9: r = a & b;   10: r = a & z16;
        11: r = a | b;  12: r = a | z16;
        13: r = a ^ b;  14: r = a ^ z16;
        default: r = ~a;
      endcase
      fo = {1'b0, fin[2], r[31], r == 0};
    end else if (op <= 21) begin
      if (op <= 17) begin
        r = b << amt;
        c = (amt == 0) ? 1'b0 : b[32-amt];
      end else begin
        r = (op <= 19) ? (b >> amt) : 32'($signed(b) >>> amt);
        c = (amt == 0) ? 1'b0 : b[amt-1];
      end
      fo = {1'b0, c, r[31], r == 0};
    end
  endfunction

  function automatic void reqs(input int op, output string rr, output string fr);
    if (op <= 2)       begin rr = "R1"; fr = "R2"; end
    else if (op <= 4)  begin rr = "R3"; fr = "R3"; end
    else if (op <= 8)  begin rr = "R4"; fr = "R4"; end
    else if (op <= 15) begin rr = "R5"; fr = "R5"; end
    else if (op <= 21) begin rr = "R6"; fr = "R7"; end
    else               begin rr = "R9"; fr = "R9"; end
  endfunction

  task automatic cyc(input bit v, input int op, input logic [31:0] a, b, input logic [15:0] imm,
                     input bit ordy);
    bit          acc, en;
    logic [31:0] r;
    logic [4:0]  idx, ib, id;
    logic [3:0]  fo;
    @(negedge clk);
    chk(out_valid === m_valid, "R10", 32'(out_valid), 32'(m_valid));
    chk(flags === m_flags, m_freq, 32'(flags), 32'(m_flags));
    if (m_valid) begin
      chk(out_result === m_res, m_rreq, out_result, m_res);
      chk(out_wb_en === m_en, m_en ? "R8" : "R9", 32'(out_wb_en), 32'(m_en));
      if (m_en) chk(out_wb_idx === m_idx, "R8", 32'(out_wb_idx), 32'(m_idx));
    end
    ib = 5'($urandom);
    id = 5'($urandom);
    in_valid = v; in_op = 5'(op); in_a = a; in_b = b; in_imm = imm;
    in_idx_b = ib; in_idx_d = id; out_ready = ordy;
    #1;
    chk(in_ready === (!m_valid || ordy), "R10", 32'(in_ready), 32'(!m_valid || ordy));
    acc = v && (!m_valid || ordy);
    if (acc) begin
      model(op, a, b, imm, ib, id, m_flags, r, en, idx, fo);
      m_valid = 1'b1; m_res = r; m_en = en; m_idx = idx; m_flags = fo;
      reqs(op, m_rreq, m_freq);
    end else if (ordy) begin
      m_valid = 1'b0;
    end
  endtask

  function automatic logic [31:0] pick();
    case ($urandom_range(0, 7))
      0: return 32'h0;
      1: return 32'hFFFF_FFFF;
      2: return 32'h7FFF_FFFF;
      3: return 32'h8000_0000;
      4: return 32'h1;
      default: return $urandom;
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) begin
      @(negedge clk);
      // R11 reset state
      chk(out_valid === 1'b0, "R11", 32'(out_valid), 0);
      chk(flags === 4'h0, "R11", 32'(flags), 0);
      chk(in_ready === 1'b1, "R11", 32'(in_ready), 1);
    end
    rst_n = 1'b1;
    // R1 R2: wrap to zero, signed overflow, short and long immediates
    cyc(1, 0, 32'h1, 32'hFFFF_FFFF, 16'h0, 1);
    cyc(1, 0, 32'h1, 32'h7FFF_FFFF, 16'h0, 1);
    cyc(1, 1, 32'h0, 32'h0, 16'hFF10, 1);
    cyc(1, 2, 32'h0, 32'h0, 16'h8000, 1);
    // R3 borrow both directions
    cyc(1, 3, 32'h7, 32'h5, 16'h0, 1);
    cyc(1, 4, 32'h7, 32'h5, 16'h0, 1);
    cyc(1, 3, 32'h1, 32'h8000_0000, 16'h0, 1);
    // carry set, then R5 logical keeps it while stalled, R4 moves keep flags
    cyc(1, 0, 32'h1, 32'hFFFF_FFFF, 16'h0, 1);
    cyc(1, 11, 32'h8000_0000, 32'h0, 16'h0, 0);
    cyc(1, 12, 32'h0, 32'h0, 16'hFFFF, 0);
    cyc(1, 12, 32'h0, 32'h0, 16'hFFFF, 0);
    cyc(1, 12, 32'h0, 32'h0, 16'hFFFF, 1);
    cyc(1, 14, 32'h0000_FFFF, 32'h0, 16'hFFFF, 1);
    cyc(1, 15, 32'hFFFF_FFFF, 32'h0, 16'h0, 1);
    cyc(1, 8, 32'h1, 32'h0, 16'h1234, 0);
    cyc(1, 7, 32'h10, 32'h0, 16'hFFF0, 0);
    cyc(0, 0, 32'h0, 32'h0, 16'h0, 1);
    cyc(1, 6, 32'h0, 32'h0, 16'h001F, 1);
    cyc(1, 5, 32'hDEAD_BEEF, 32'h0, 16'h0, 1);
    // R6 R7 shifts: amount above 31 from a register, zero amount, sign fill
    cyc(1, 16, 32'h21, 32'h8000_0001, 16'h0, 1);
    cyc(1, 17, 32'h0, 32'h8000_0001, 16'hFFE0, 1);
    cyc(1, 20, 32'hFFFF_FFFF, 32'h8000_0000, 16'h0, 1);
    cyc(1, 19, 32'h0, 32'h0000_0003, 16'h0001, 1);
    cyc(1, 21, 32'h0, 32'hF000_0000, 16'h0004, 1);
    // R9 undefined codes
    cyc(1, 22, 32'h5, 32'h5, 16'h5, 1);
    cyc(1, 31, 32'h5, 32'h5, 16'h5, 1);
    for (int i = 0; i < 6000; i++) begin
      int op;
      op = ($urandom_range(0, 9) == 0) ? int'($urandom_range(22, 31)) : int'($urandom_range(0, 21));
      cyc($urandom_range(0, 3) != 0, op, pick(), pick(), 16'($urandom),
          $urandom_range(0, 2) != 0);
    end
    cyc(0, 0, 32'h0, 32'h0, 16'h0, 1);
    cyc(0, 0, 32'h0, 32'h0, 16'h0, 1);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule